// File: doc/BRIEF.md
# Overcurrent One-Shot and Undervoltage Fault Monitor

This block sits beside a bridge gate controller and decides when the gates must be held off for protection. It watches two digital overcurrent comparator outputs, one per bridge leg (A and B), and one supply-undervoltage indication. An overcurrent trip that survives a two-cycle glitch filter starts an off-time timer. The timer is retriggerable and its length is a parameter in clock cycles, which replaces the external resistor-capacitor timing network. While the timer runs, the block raises gate inhibit signals. It also drives two active-low alert outputs, which model open-drain enables.

A static mode input sets how the two legs are treated. In full-bridge mode (`mode_full` = 1), a trip on either leg starts one shared timer that inhibits both legs. `alert_b_n` then acts as a current-limit flag that is low for the whole off time. `alert_a_n` acts as a general fault flag that is low for an overcurrent or for an undervoltage. In half-bridge mode (`mode_full` = 0), each leg has its own timer and inhibit signal, and each alert reports the faults of its own leg. Undervoltage is not timed: it inhibits every gate and pulls the relevant alerts low for exactly as long as `uv_det` is high. Every indication clears by itself, with no acknowledge.

Each comparator input first passes through a synchroniser (state `QS_QUIET` / `QS_SEEN` qualifier, transitions: QUIET→SEEN on a synchronised high, SEEN→SEEN while it stays high, SEEN→QUIET on a low). A trip is accepted only in `QS_SEEN` with the input still high. Each timer is a two-state machine, `OS_IDLE` and `OS_HOLD`:
- IDLE→HOLD on an accepted trip, loading the count.
- HOLD→HOLD on a further trip (reload) or while the count is non-zero (decrement).
- HOLD→IDLE when the count reaches zero with no trip.

Top module: `ocl_fault_monitor`

## Requirements
- R1: During and after reset, with no inputs high, `inhibit_a` and `inhibit_b` are 0 and `alert_a_n` and `alert_b_n` are 1.
- R2: A comparator input that is high at only one sampling edge (with the default two-stage synchroniser) has no effect on any output.
- R3: A comparator input that is high at two consecutive rising edges k and k+1 is accepted, and its leg's outputs become asserted right after edge k+3.
- R4: If a comparator input was last high at edges j-1 and j, its timer releases the outputs right after edge j+2+HOLD_CYCLES.
- R5: A new accepted trip while a timer is running reloads it, so the off time is measured from the last accepted trip.
- R6: In full-bridge mode (`mode_full`=1), a trip on either leg asserts both `inhibit_a` and `inhibit_b`, and pulls both `alert_b_n` (current limit) and `alert_a_n` (fault) low.
- R7: In full-bridge mode, `uv_det`=1 asserts both inhibits and pulls `alert_a_n` low, and it leaves `alert_b_n` under control of the timer alone.
- R8: In half-bridge mode (`mode_full`=0), a trip on leg A asserts only `inhibit_a` and `alert_a_n`, and a trip on leg B asserts only `inhibit_b` and `alert_b_n`. Each leg times its off period independently.
- R9: In half-bridge mode, `uv_det`=1 asserts both inhibits and pulls both alerts low.
- R10: Undervoltage effects follow `uv_det` in the same cycle and vanish as soon as it drops, unless a timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_full | input | 1 | 1 = full bridge, 0 = two independent half bridges |
| uv_det | input | 1 | Supply undervoltage indication, active high |
| oc_a_trip | input | 1 | Leg A overcurrent comparator output, asynchronous |
| oc_b_trip | input | 1 | Leg B overcurrent comparator output, asynchronous |
| inhibit_a | output | 1 | Force all leg A gates off |
| inhibit_b | output | 1 | Force all leg B gates off |
| alert_a_n | output | 1 | Active low: bridge fault (full) or leg A fault (half) |
| alert_b_n | output | 1 | Active low: current limit (full) or leg B fault (half) |

## Verification
The bench applies single-edge pulses and alternating on-off patterns. A design that accepts a trip on one sample would open an off time on a glitch. Re-trips that land a few cycles into a running off time expose a timer that ignores retriggers or adds its count instead of restarting. Undervoltage is raised both alone and during a running shot in each mode. This catches a current-limit flag that wrongly reacts to undervoltage in full-bridge mode, and an undervoltage that latches or waits for the timer. In half-bridge mode, trips on one leg with the other quiet show up any leakage between the two legs' timers or alerts.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

    localparam int NUM_LEGS = 2;

    typedef enum logic {
        QS_QUIET,
        QS_SEEN
    } qual_state_t;

    typedef enum logic {
        OS_IDLE,
        OS_HOLD
    } shot_state_t;

endpackage

// File: rtl/ocl_trip_qual.sv
module ocl_trip_qual
    import ocl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic accept
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    qual_state_t            state, state_nxt;

    // synchroniser chain
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= raw_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= QS_QUIET;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            QS_QUIET: if (synced)  state_nxt = QS_SEEN;
            QS_SEEN:  if (!synced) state_nxt = QS_QUIET;
            default:  state_nxt = QS_QUIET;
        endcase
    end

    // output process
    always_comb begin
        accept = (state == QS_SEEN) && synced;
    end

endmodule

// File: rtl/ocl_oneshot.sv
module ocl_oneshot
    import ocl_pkg::*;
#(
    parameter int HOLD_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

    shot_state_t      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            OS_IDLE: begin
                if (fire) begin
                    state_nxt = OS_HOLD;
                    cnt_nxt   = RELOAD;
                end
            end
            OS_HOLD: begin
                if (fire) begin
                    cnt_nxt = RELOAD;
                end else if (cnt == '0) begin
                    state_nxt = OS_IDLE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: begin
                state_nxt = OS_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // output process
    always_comb begin
        active = (state == OS_HOLD);
    end

endmodule

// File: rtl/ocl_fault_monitor.sv
module ocl_fault_monitor
    import ocl_pkg::*;
#(
    parameter int HOLD_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_full,
    input  logic uv_det,
    input  logic oc_a_trip,
    input  logic oc_b_trip,
    output logic inhibit_a,
    output logic inhibit_b,
    output logic alert_a_n,
    output logic alert_b_n
);

    logic [NUM_LEGS-1:0] raw_trip;
    logic [NUM_LEGS-1:0] acc;
    logic [NUM_LEGS-1:0] shot_fire;
    logic [NUM_LEGS-1:0] shot_on;

    assign raw_trip = {oc_b_trip, oc_a_trip};

    // shared shot in full-bridge mode, one per leg otherwise
    always_comb begin
        if (mode_full) begin
            shot_fire[0] = acc[0] | acc[1];
            shot_fire[1] = 1'b0;
        end else begin
            shot_fire = acc;
        end
    end

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            ocl_trip_qual #(
                .SYNC_STAGES(SYNC_STAGES)
            ) u_qual (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_in (raw_trip[g]),
                .accept (acc[g])
            );

            ocl_oneshot #(
                .HOLD_CYCLES(HOLD_CYCLES)
            ) u_shot (
                .clk    (clk),
                .rst_n  (rst_n),
                .fire   (shot_fire[g]),
                .active (shot_on[g])
            );
        end
    endgenerate

    // output process
    always_comb begin
        if (mode_full) begin
            inhibit_a = shot_on[0] | uv_det;
            inhibit_b = shot_on[0] | uv_det;
            alert_a_n = ~(shot_on[0] | uv_det);
            alert_b_n = ~shot_on[0];
        end else begin
            inhibit_a = shot_on[0] | uv_det;
            inhibit_b = shot_on[1] | uv_det;
            alert_a_n = ~(shot_on[0] | uv_det);
            alert_b_n = ~(shot_on[1] | uv_det);
        end
    end

endmodule

// File: rtl/ocl_fault_monitor_chk.sv
module ocl_fault_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_full,
    input logic       uv_det,
    input logic       oc_a_trip,
    input logic       oc_b_trip,
    input logic       inhibit_a,
    input logic       inhibit_b,
    input logic       alert_a_n,
    input logic       alert_b_n,
    input logic [1:0] shot_on
);

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shot_on[0]) |->
            (($past(oc_a_trip, 3) && $past(oc_a_trip, 4)) ||
             ($past(oc_b_trip, 3) && $past(oc_b_trip, 4))));

    // R2
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shot_on[1]) |-> ($past(oc_b_trip, 3) && $past(oc_b_trip, 4)));

    // R6
    full_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_full |-> (inhibit_a == inhibit_b));

    // R7
    full_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_full && uv_det) |-> (!alert_a_n && inhibit_a && inhibit_b));

    // R9
    half_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_full && uv_det) |->
            (!alert_a_n && !alert_b_n && inhibit_a && inhibit_b));

    // R8
    half_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_full && !uv_det) |->
            ((inhibit_a == !alert_a_n) && (inhibit_b == !alert_b_n)));

endmodule

bind ocl_fault_monitor ocl_fault_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_full (mode_full),
    .uv_det    (uv_det),
    .oc_a_trip (oc_a_trip),
    .oc_b_trip (oc_b_trip),
    .inhibit_a (inhibit_a),
    .inhibit_b (inhibit_b),
    .alert_a_n (alert_a_n),
    .alert_b_n (alert_b_n),
    .shot_on   (shot_on)
);

// File: tb/tb_ocl_fault_monitor.sv
`timescale 1ns/100ps
module tb_ocl_fault_monitor;

    localparam int HOLD = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_full = 1'b1;
    logic uv_det = 1'b0;
    logic oc_a_trip = 1'b0;
    logic oc_b_trip = 1'b0;
    logic inhibit_a, inhibit_b, alert_a_n, alert_b_n;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ocl_fault_monitor #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .mode_full(mode_full), .uv_det(uv_det),
        .oc_a_trip(oc_a_trip), .oc_b_trip(oc_b_trip),
        .inhibit_a(inhibit_a), .inhibit_b(inhibit_b),
        .alert_a_n(alert_a_n), .alert_b_n(alert_b_n)
    );

    // behavioural reference: sample history and remaining off time
    bit hist_a[$];
    bit hist_b[$];
    int rem0 = 0;
    int rem1 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_a.delete();
            hist_b.delete();
            rem0 = 0;
            rem1 = 0;
        end else begin
            bit ta, tb, f0, f1;
            hist_a.push_front(oc_a_trip);
            hist_b.push_front(oc_b_trip);
            if (hist_a.size() > 8) void'(hist_a.pop_back());
            if (hist_b.size() > 8) void'(hist_b.pop_back());
            // accepted when high two and three edges back
            ta = (hist_a.size() >= 4) && hist_a[2] && hist_a[3];
            tb = (hist_b.size() >= 4) && hist_b[2] && hist_b[3];
            f0 = mode_full ? (ta || tb) : ta;
            f1 = mode_full ? 1'b0 : tb;
            if (f0) rem0 = HOLD; else if (rem0 > 0) rem0--;
            if (f1) rem1 = HOLD; else if (rem1 > 0) rem1--;
        end
    end

    task automatic check_out(string tag, string nm, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) begin
            bit s0, s1, ea, eb, xa, xb;
            s0 = (rem0 > 0);
            s1 = (rem1 > 0);
            if (mode_full) begin
                ea = s0 || uv_det; eb = s0 || uv_det;
                xa = !(s0 || uv_det); xb = !s0;
            end else begin
                ea = s0 || uv_det; eb = s1 || uv_det;
                xa = !(s0 || uv_det); xb = !(s1 || uv_det);
            end
            check_out(cur_req, "inhibit_a", inhibit_a, ea);
            check_out(cur_req, "inhibit_b", inhibit_b, eb);
            check_out(cur_req, "alert_a_n", alert_a_n, xa);
            check_out(cur_req, "alert_b_n", alert_b_n, xb);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_a(int n);
        @(negedge clk); oc_a_trip = 1'b1;
        idle(n);
        oc_a_trip = 1'b0;
    endtask

    task automatic pulse_b(int n);
        @(negedge clk); oc_b_trip = 1'b1;
        idle(n);
        oc_b_trip = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 50000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        idle(5);
        rst_n = 1'b1;
        idle(4);

        // full-bridge mode
        cur_req = "R2";
        pulse_a(1); idle(10);
        pulse_b(1); idle(10);
        for (int i = 0; i < 4; i++) begin pulse_a(1); idle(1); end
        idle(10);

        cur_req = "R3";
        pulse_a(2); idle(HOLD + 8);

        cur_req = "R4";
        pulse_a(5); idle(HOLD + 8);

        cur_req = "R5";
        pulse_a(2); idle(5); pulse_a(3); idle(3); pulse_b(2); idle(HOLD + 8);

        cur_req = "R6";
        pulse_b(3); idle(HOLD + 8);

        cur_req = "R7";
        @(negedge clk); uv_det = 1'b1; idle(5); uv_det = 1'b0; idle(3);
        pulse_a(2); idle(4); uv_det = 1'b1; idle(3); uv_det = 1'b0; idle(HOLD + 6);

        cur_req = "R10";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); uv_det = 1'b1; @(negedge clk); uv_det = 1'b0; idle(1);
        end
        idle(4);

        // half-bridge mode, switched while idle
        @(negedge clk); mode_full = 1'b0; idle(4);

        cur_req = "R8";
        pulse_a(2); idle(HOLD + 8);
        pulse_b(3); idle(HOLD + 8);
        pulse_a(2); idle(5); pulse_b(2); idle(4); pulse_a(2); idle(HOLD + 8);
        pulse_b(1); idle(10);

        cur_req = "R9";
        @(negedge clk); uv_det = 1'b1; idle(4); uv_det = 1'b0; idle(3);
        pulse_b(2); idle(3); uv_det = 1'b1; idle(2); uv_det = 1'b0; idle(HOLD + 8);

        cur_req = "R10";
        @(negedge clk); uv_det = 1'b1; @(negedge clk); uv_det = 1'b0; idle(4);

        finish_run();
    end

endmodule